// File: doc/BRIEF.md
# Chained Two-Register-Set DMA Channel

This block is one DMA channel. It moves data words between a peripheral stream and a plain memory master port. An active register pair holds a running address and an end limit, and this pair drives the transfer now in progress. A second pair holds the start and stop addresses of the segment that follows. Software can therefore refill the second pair while the first one is still being consumed. When the running address meets the limit, one armed flag decides what happens. If the flag is armed, the channel swaps in the queued segment and keeps going. If it is not, the channel ends the chain.

A control/status word accepts one-hot write commands: enable, arm, the two direction bits, acknowledge, reset and buffer flush. The same word reports the channel's state. A level interrupt follows the completion bit. Read-only shadow copies of all four address registers let software find the address where a stopped transfer ended, and from it the transferred length. When the channel is built with frame marking, a limit whose top bit is set is an end-of-frame marker and is biased by 15. The channel removes both before it compares or reports the limit.

Top module: `chain_dma`

## Requirements
- R1: After reset the control word reads 0, `irq` is low and `mem_req` is low.
- R2: Writing the value 0 to the control word (select 0) changes no state bit. Control write bits: 0 enable, 1 arm, 2 direction stream-to-memory, 3 direction memory-to-stream, 4 acknowledge, 5 reset, 6 flush. Control read bits: 0 enable, 1 armed, 2 stream-to-memory, 3 complete, 4 bus exception.
- R3: A write of reset together with acknowledge leaves the complete, armed and enable bits all 0. Reset also clears the bus-exception bit and leaves the direction bit alone.
- R4: In stream-to-memory mode, each accepted beat writes the next stream word at the running address. The address then grows by DW/8 bytes, until it equals the limit.
- R5: In memory-to-stream mode, words read at ascending addresses appear on the output stream in the same order.
- R6: When the address meets the limit while armed, the queued start/stop pair becomes the active pair. Complete rises, enable stays 1, armed drops to 0, and the transfer continues at the start address.
- R7: When the address meets the limit while not armed, complete rises, enable drops to 0 and no further memory request is made.
- R8: `irq` equals the complete bit. It stays high until an acknowledge is written.
- R9: A beat answered with `mem_err` writes nothing, stops the channel and sets complete and bus exception. The saved limit holds the failing address. Bus exception survives an acknowledge and is cleared only by reset.
- R10: On a stop, the saved limit (select 6) holds the address where the transfer ended. The saved start and stop (selects 7 and 8) hold the values last written to the queued pair.
- R11: With frame marking, a limit that has bit 31 set ends the transfer at (limit with bit 31 cleared) minus 15. The saved limit reports that stripped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (0 control, 1 address, 2 limit, 3 start, 4 stop, 5..8 saved copies) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (stream-to-memory) |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Accepted beat failed |
| in_valid | input | 1 | Stream input word valid |
| in_data | input | DW | Stream input word |
| in_ready | output | 1 | Stream input word taken |
| out_valid | output | 1 | Stream output word valid |
| out_data | output | DW | Stream output word |
| out_ready | input | 1 | Stream output sink ready |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions assume that software never writes the control word in the same cycle as a limit hit or a bus error, and never rewrites the active address while the channel is moving data. They also assume that the stream source keeps its word steady until the channel takes it. The stimulus follows these rules. It loads registers only while the channel is idle. It acknowledges a hand-off at once, while the next segment still has several beats to run, and the source it uses is always valid and changes its data only on a handshake.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    localparam int REG_W = 32;
    localparam int SEL_W = 4;
    localparam logic [REG_W-1:0] FRAME_BIAS = 32'd15;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL       = 4'd0,
        SEL_CUR_ADDR   = 4'd1,
        SEL_CUR_LIM    = 4'd2,
        SEL_CONT_START = 4'd3,
        SEL_CONT_STOP  = 4'd4,
        SEL_SAV_ADDR   = 4'd5,
        SEL_SAV_LIM    = 4'd6,
        SEL_SAV_START  = 4'd7,
        SEL_SAV_STOP   = 4'd8
    } reg_sel_e;

    // Readable status, packed so that enable sits at bit 0.
    typedef struct packed {
        logic bus_exc;
        logic done;
        logic dir_in;
        logic update;
        logic enable;
    } chan_stat_t;

    // One-hot write commands.
    typedef struct packed {
        logic flush;
        logic reset;
        logic clr_done;
        logic dir_out;
        logic dir_in;
        logic update;
        logic enable;
    } chan_cmd_t;

    function automatic chan_cmd_t decode_cmd(input logic [REG_W-1:0] w);
        chan_cmd_t c;
        c = chan_cmd_t'(w[6:0]);
        return c;
    endfunction

    // Remove an end-of-frame marker and its bias from a limit value.
    function automatic logic [REG_W-1:0] strip_mark(input logic [REG_W-1:0] lim);
        logic [REG_W-1:0] r;
        if (lim[REG_W-1])
            r = {1'b0, lim[REG_W-2:0]} - FRAME_BIAS;
        else
            r = lim;
        return r;
    endfunction

endpackage

// File: rtl/chain_dma_addr.sv
module chain_dma_addr
    import chain_dma_pkg::*;
#(
    parameter int STEP       = 4,
    parameter bit FRAME_MARK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             beat,
    input  logic             handoff,
    input  logic             stop_evt,
    output logic [REG_W-1:0] cur_addr,
    output logic [REG_W-1:0] cur_lim,
    output logic [REG_W-1:0] cont_start,
    output logic [REG_W-1:0] cont_stop,
    output logic [REG_W-1:0] sav_addr,
    output logic [REG_W-1:0] sav_lim,
    output logic [REG_W-1:0] sav_start,
    output logic [REG_W-1:0] sav_stop,
    output logic             hit
);

    localparam logic [REG_W-1:0] STEP_W = REG_W'(STEP);

    logic [REG_W-1:0] eff_lim;
    logic             wr_cur_addr;
    logic             wr_cur_lim;
    logic             wr_start;
    logic             wr_stop;

    assign wr_cur_addr = wr_en && (reg_sel_e'(wr_sel) == SEL_CUR_ADDR);
    assign wr_cur_lim  = wr_en && (reg_sel_e'(wr_sel) == SEL_CUR_LIM);
    assign wr_start    = wr_en && (reg_sel_e'(wr_sel) == SEL_CONT_START);
    assign wr_stop     = wr_en && (reg_sel_e'(wr_sel) == SEL_CONT_STOP);

    generate
        if (FRAME_MARK) begin : g_mark
            assign eff_lim = strip_mark(cur_lim);
        end else begin : g_plain
            assign eff_lim = cur_lim;
        end
    endgenerate

    assign hit = (cur_addr == eff_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            cur_lim    <= '0;
            cont_start <= '0;
            cont_stop  <= '0;
            sav_addr   <= '0;
            sav_lim    <= '0;
            sav_start  <= '0;
            sav_stop   <= '0;
        end else begin
            if (handoff) begin
                cur_addr <= cont_start;
                cur_lim  <= cont_stop;
                sav_addr <= cont_start;
                sav_lim  <= cont_stop;
            end else begin
                if (beat)
                    cur_addr <= cur_addr + STEP_W;
                if (wr_cur_addr) begin
                    cur_addr <= wr_data;
                    sav_addr <= wr_data;
                end
                if (wr_cur_lim) begin
                    cur_lim <= wr_data;
                    sav_lim <= wr_data;
                end
                if (stop_evt)
                    sav_lim <= cur_addr;
            end
            if (wr_start) begin
                cont_start <= wr_data;
                sav_start  <= wr_data;
            end
            if (wr_stop) begin
                cont_stop <= wr_data;
                sav_stop  <= wr_data;
            end
        end
    end

    // R4: an accepted beat moves the running address by one word
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (beat && !wr_cur_addr && !handoff) |=> (cur_addr == $past(cur_addr) + STEP_W));

    // R6: a hand-off installs the queued start address
    p_handoff_load_r6: assert property (@(posedge clk) disable iff (rst)
        handoff |=> (cur_addr == $past(cont_start)));

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
    import chain_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hit,
    input  logic             bus_err,
    output chan_stat_t       stat,
    output logic             handoff,
    output logic             stop_evt,
    output logic             flush
);

    chan_cmd_t  cmd;
    chan_stat_t nxt;
    logic       limit_evt;
    logic       err_evt;

    assign cmd       = decode_cmd(wr_data);
    assign limit_evt = stat.enable && hit;
    assign err_evt   = stat.enable && bus_err;
    assign handoff   = limit_evt && stat.update;
    assign stop_evt  = (limit_evt && !stat.update) || err_evt;
    assign flush     = wr_en && (cmd.reset || cmd.flush);

    always_comb begin
        nxt = stat;
        if (wr_en) begin
            if (cmd.reset) begin
                nxt.enable  = 1'b0;
                nxt.update  = 1'b0;
                nxt.bus_exc = 1'b0;
            end else begin
                if (cmd.enable) nxt.enable = 1'b1;
                if (cmd.update) nxt.update = 1'b1;
            end
            if (cmd.clr_done) nxt.done = 1'b0;
            if (cmd.dir_in)
                nxt.dir_in = 1'b1;
            else if (cmd.dir_out)
                nxt.dir_in = 1'b0;
        end
        // Channel events take precedence over a same-cycle write.
        if (handoff) begin
            nxt.update = 1'b0;
            nxt.done   = 1'b1;
        end else if (stop_evt) begin
            nxt.enable = 1'b0;
            nxt.done   = 1'b1;
        end
        if (err_evt)
            nxt.bus_exc = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat <= '0;
        else
            stat <= nxt;
    end

    // R6: chained hand-off keeps running, disarmed, with complete raised
    p_handoff_r6: assert property (@(posedge clk) disable iff (rst)
        handoff |=> (stat.enable && stat.done && !stat.update));

    // R7: end-of-chain stop
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (!stat.enable && stat.done));

    // R9: bus exception is sticky until a reset command
    p_exc_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (stat.bus_exc && !(wr_en && cmd.reset)) |=> stat.bus_exc);

    // R3: reset with acknowledge clears the three run bits
    p_reset_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd.reset && cmd.clr_done && !limit_evt && !err_evt)
        |=> (!stat.done && !stat.enable && !stat.update));

endmodule

// File: rtl/chain_dma_mover.sv
module chain_dma_mover
    import chain_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             dir_in,
    input  logic             hit,
    input  logic             flush,
    input  logic [REG_W-1:0] cur_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    input  logic             mem_err,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    output logic             beat,
    output logic             bus_err
);

    logic          active;
    logic          accept;
    logic          buf_full;
    logic [DW-1:0] buf_data;

    assign active    = enable && !hit;
    assign mem_req   = active && (dir_in ? in_valid : !buf_full);
    assign mem_we    = dir_in;
    assign mem_addr  = cur_addr;
    assign mem_wdata = in_data;
    assign accept    = mem_req && mem_ready;
    assign beat      = accept && !mem_err;
    assign bus_err   = accept && mem_err;
    assign in_ready  = dir_in && accept;
    assign out_valid = buf_full;
    assign out_data  = buf_data;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else begin
            if (out_valid && out_ready)
                buf_full <= 1'b0;
            if (beat && !dir_in) begin
                buf_full <= 1'b1;
                buf_data <= mem_rdata;
            end
        end
    end

    // R7: no memory request once the address has met the limit
    p_no_req_at_limit_r7: assert property (@(posedge clk) disable iff (rst)
        hit |-> !mem_req);

    // R5: an offered output word is held until taken
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int DW         = 32,
    parameter bit FRAME_MARK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    input  logic             mem_err,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    output logic             irq
);

    localparam int STEP = DW / 8;

    chan_stat_t       stat;
    logic             handoff;
    logic             stop_evt;
    logic             flush;
    logic             hit;
    logic             beat;
    logic             bus_err;
    logic             wr_ctrl;
    logic [REG_W-1:0] cur_addr, cur_lim, cont_start, cont_stop;
    logic [REG_W-1:0] sav_addr, sav_lim, sav_start, sav_stop;

    assign wr_ctrl = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);

    chain_dma_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ctrl),
        .wr_data  (reg_wdata),
        .hit      (hit),
        .bus_err  (bus_err),
        .stat     (stat),
        .handoff  (handoff),
        .stop_evt (stop_evt),
        .flush    (flush)
    );

    chain_dma_addr #(
        .STEP       (STEP),
        .FRAME_MARK (FRAME_MARK)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .wr_sel     (reg_sel),
        .wr_data    (reg_wdata),
        .beat       (beat),
        .handoff    (handoff),
        .stop_evt   (stop_evt),
        .cur_addr   (cur_addr),
        .cur_lim    (cur_lim),
        .cont_start (cont_start),
        .cont_stop  (cont_stop),
        .sav_addr   (sav_addr),
        .sav_lim    (sav_lim),
        .sav_start  (sav_start),
        .sav_stop   (sav_stop),
        .hit        (hit)
    );

    chain_dma_mover #(
        .DW (DW)
    ) u_mover (
        .clk       (clk),
        .rst       (rst),
        .enable    (stat.enable),
        .dir_in    (stat.dir_in),
        .hit       (hit),
        .flush     (flush),
        .cur_addr  (cur_addr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .mem_err   (mem_err),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .beat      (beat),
        .bus_err   (bus_err)
    );

    assign irq = stat.done;

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_CTRL:       reg_rdata = REG_W'(stat);
            SEL_CUR_ADDR:   reg_rdata = cur_addr;
            SEL_CUR_LIM:    reg_rdata = cur_lim;
            SEL_CONT_START: reg_rdata = cont_start;
            SEL_CONT_STOP:  reg_rdata = cont_stop;
            SEL_SAV_ADDR:   reg_rdata = sav_addr;
            SEL_SAV_LIM:    reg_rdata = sav_lim;
            SEL_SAV_START:  reg_rdata = sav_start;
            SEL_SAV_STOP:   reg_rdata = sav_stop;
            default:        reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/chain_dma_tb.sv
module chain_dma_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready, mem_err;
    logic        in_valid;
    logic [31:0] in_data;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:127];
    logic        stall_on = 1'b0;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = 32'd0;
    logic        src_on = 1'b0;
    int          in_cnt = 0;
    int          out_cnt = 0;
    logic [31:0] out_q [0:15];
    logic [7:0]  cyc = 8'd0;

    always #10 clk = ~clk;

    chain_dma u_dut (
        .clk (clk), .rst (rst),
        .reg_wr (reg_wr), .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata), .mem_ready (mem_ready), .mem_err (mem_err),
        .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
        .out_valid (out_valid), .out_data (out_data), .out_ready (out_ready),
        .irq (irq)
    );

    // Memory and stream models
    assign mem_ready = stall_on ? cyc[0] : 1'b1;
    assign mem_err   = err_on && (mem_addr == err_addr);
    assign mem_rdata = mem[mem_addr[8:2]];
    assign in_valid  = src_on;
    assign in_data   = 32'hA000_0000 | in_cnt;

    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (mem_req && mem_ready && mem_we && !mem_err)
            mem[mem_addr[8:2]] <= mem_wdata;
        if (in_valid && in_ready)
            in_cnt <= in_cnt + 1;
        if (out_valid && out_ready) begin
            if (out_cnt < 16) out_q[out_cnt] <= out_data;
            out_cnt <= out_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n;
        n = 0;
        while (!irq && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, irq}, 32'd1);
    endtask

    // R1: reset state
    task automatic t_reset;
        logic [31:0] v;
        rd(4'd0, v);
        chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    // R2: zero write is inert
    task automatic t_zero_write;
        logic [31:0] v;
        wr(4'd0, 32'h04);
        wr(4'd0, 32'h00);
        rd(4'd0, v);
        chk("R2 ctrl after zero write", v, 32'h04);
        chk("R2 irq", {31'd0, irq}, 32'd0);
    endtask

    // R4, R7, R8, R10: stream-to-memory single segment with stalls
    task automatic t_in_single;
        logic [31:0] v;
        int base;
        stall_on = 1'b1;
        src_on = 1'b1;
        wr(4'd0, 32'h24);
        wr(4'd0, 32'h00);
        wr(4'd1, 32'h40);
        wr(4'd2, 32'h50);
        base = in_cnt;
        wr(4'd0, 32'h05);
        wait_irq("R7 irq at end of chain");
        rd(4'd0, v);
        chk("R7 ctrl after stop", v, 32'h0C);
        repeat (3) @(negedge clk);
        chk("R7 no request after stop", {31'd0, mem_req}, 32'd0);
        for (int k = 0; k < 4; k++)
            chk("R4 word written", mem[8'h10 + k], 32'hA000_0000 | (base + k));
        rd(4'd6, v);
        chk("R10 saved limit", v, 32'h50);
        chk("R8 irq held", {31'd0, irq}, 32'd1);
        wr(4'd0, 32'h14);
        chk("R8 irq after ack", {31'd0, irq}, 32'd0);
        rd(4'd0, v);
        chk("R8 ctrl after ack", v, 32'h04);
        src_on = 1'b0;
        stall_on = 1'b0;
    endtask

    // R5, R6, R10: memory-to-stream with one chained hand-off
    task automatic t_out_chain;
        logic [31:0] v;
        int base;
        mem[8'h20] = 32'h1111_0000;
        mem[8'h21] = 32'h1111_0001;
        for (int k = 0; k < 3; k++) mem[8'h30 + k] = 32'h2222_0000 + k;
        wr(4'd0, 32'h28);
        wr(4'd0, 32'h00);
        wr(4'd1, 32'h80);
        wr(4'd2, 32'h88);
        wr(4'd3, 32'hC0);
        wr(4'd4, 32'hCC);
        base = out_cnt;
        wr(4'd0, 32'h0B);
        wait_irq("R6 irq at hand-off");
        rd(4'd0, v);
        chk("R6 ctrl after hand-off", v, 32'h09);
        rd(4'd2, v);
        chk("R6 active limit reloaded", v, 32'hCC);
        wr(4'd0, 32'h18);
        wait_irq("R7 irq at end of second segment");
        rd(4'd0, v);
        chk("R7 ctrl after chain end", v, 32'h08);
        repeat (4) @(negedge clk);
        chk("R5 output count", out_cnt - base, 32'd5);
        chk("R5 word 0", out_q[base + 0], 32'h1111_0000);
        chk("R5 word 1", out_q[base + 1], 32'h1111_0001);
        for (int k = 0; k < 3; k++)
            chk("R5 chained word", out_q[base + 2 + k], 32'h2222_0000 + k);
        rd(4'd6, v);
        chk("R10 saved limit after chain", v, 32'hCC);
        rd(4'd7, v);
        chk("R10 saved start", v, 32'hC0);
        rd(4'd8, v);
        chk("R10 saved stop", v, 32'hCC);
        wr(4'd0, 32'h10);
    endtask

    // R9, R3: bus error, sticky exception, reset with acknowledge
    task automatic t_bus_err;
        logic [31:0] v;
        mem[8'h42] = 32'h5EE0_0042;
        err_on = 1'b1;
        err_addr = 32'h108;
        src_on = 1'b1;
        wr(4'd0, 32'h24);
        wr(4'd0, 32'h00);
        wr(4'd1, 32'h100);
        wr(4'd2, 32'h120);
        wr(4'd0, 32'h05);
        wait_irq("R9 irq on bus error");
        rd(4'd0, v);
        chk("R9 ctrl after error", v, 32'h1C);
        rd(4'd6, v);
        chk("R9 saved limit is failing address", v, 32'h108);
        chk("R9 failing word not written", mem[8'h42], 32'h5EE0_0042);
        src_on = 1'b0;
        err_on = 1'b0;
        wr(4'd0, 32'h14);
        rd(4'd0, v);
        chk("R9 exception survives ack", v, 32'h14);
        wr(4'd0, 32'h02);
        wr(4'd0, 32'h01);
        wr(4'd0, 32'h30);
        rd(4'd0, v);
        chk("R3 run bits clear", v & 32'h0B, 32'h0);
        chk("R3 ctrl after reset", v, 32'h04);
    endtask

    // R11: frame-marked limit
    task automatic t_frame;
        logic [31:0] v;
        int base;
        mem[8'h62] = 32'hDEAD_0062;
        src_on = 1'b1;
        wr(4'd0, 32'h24);
        wr(4'd0, 32'h00);
        wr(4'd1, 32'h180);
        wr(4'd2, 32'h8000_0197);
        base = in_cnt;
        wr(4'd0, 32'h05);
        wait_irq("R11 irq at marked limit");
        rd(4'd0, v);
        chk("R11 ctrl", v, 32'h0C);
        rd(4'd6, v);
        chk("R11 saved limit stripped", v, 32'h188);
        chk("R11 word 0", mem[8'h60], 32'hA000_0000 | base);
        chk("R11 word 1", mem[8'h61], 32'hA000_0000 | (base + 1));
        chk("R11 no write past end", mem[8'h62], 32'hDEAD_0062);
        src_on = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_write();
        t_in_single();
        t_out_chain();
        t_bus_err();
        t_frame();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule